// File: doc/BRIEF.md
# Multi-Channel Timer and PWM Unit

This block is one shared count engine with a small group of channels that each use its count value. A prescaler divides the clock by a selectable power of two. The main counter then either runs freely over its full width or wraps at a programmable terminal value. It counts either upward only or upward and then back down. Each channel picks one job. It can timestamp edges on an external input, act on its output pin when the count matches a compare value, or produce an edge-aligned pulse-width-modulated output.

Software sets the block up through a write-only register port. The port holds the timer control word, the terminal value, a write-one-to-clear flag register, and a configuration word and compare value for each channel. Terminal and compare values pass through a holding stage, so a new period or duty only starts on a period boundary. Each channel has its own sticky event flag, and the timer has a separate terminal-count flag. Each flag has an interrupt line gated by its own enable.

Top module: `tpwm_top`

## Requirements
- R1: While reset is held low, and after it is released, the count, all flags, all channel pins, all interrupt lines and all captured values read zero.
- R2: Control word at address 0 holds these fields: bit0 run, bit1 modulo enable, bit2 up/down, bits 5:3 prescale exponent P, bit6 terminal interrupt enable. While running, the count moves once every 2^P clocks. While run is clear, the count holds its value.
- R3: In up-only mode the count climbs by one and wraps to zero after reaching the terminal value. The terminal value is the active modulo when modulo is enabled and all ones otherwise. The wrap sets the terminal-count flag.
- R4: In up/down mode the count climbs to the terminal value and then descends. The terminal-count flag is set when the count arrives back at zero, and the count then climbs again.
- R5: The modulo (address 1) and the channel compare values (address 9+2n) are held in a buffer. A buffered value becomes active at the wrap to zero, or on the clock after the write while the timer is stopped.
- R6: Channel n's configuration sits at address 8+2n: bits 1:0 mode (00 off, 01 capture, 10 compare, 11 PWM), bits 3:2 select, bit4 interrupt enable. In capture mode, select 01 picks rising edges, 10 falling edges and 11 both. The input passes through two synchronizing flops. On the chosen edge the current count is stored in the channel's value output and the channel flag is set.
- R7: In compare mode a match is a prescaler step taken while the count equals the active compare value. On a match the pin toggles (select 01), clears (10) or sets (11), and the channel flag is set.
- R8: In PWM mode the pin is high while the count is below the active compare value. A compare value of zero keeps the pin low, a value above the terminal value keeps it high, and a match sets the channel flag.
- R9: Writing address 2 clears each flag whose data bit is one: bits n-1:0 for the channel flags, bit 15 for the terminal-count flag. Zero bits and writes to other addresses leave flags alone. A new event in the same cycle wins over the clear.
- R10: A channel interrupt is high exactly when that channel's flag and enable are both set. The terminal interrupt is high exactly when the terminal flag and its enable are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| cap_in | input | NCH | Asynchronous capture inputs, one per channel |
| ch_out | output | NCH | Channel pin outputs |
| count | output | CW | Current counter value |
| ch_value | output | NCH*CW | Captured count per channel, channel n at bits n*CW upward |
| ch_flag | output | NCH | Sticky channel event flags |
| tc_flag | output | 1 | Sticky terminal-count flag |
| ch_irq | output | NCH | Channel interrupt lines |
| tc_irq | output | 1 | Terminal-count interrupt line |

## Verification
The bound checker watches several rules on every clock. The count only ever steps by one or lands on zero. The terminal flag only rises on a zero count. No flag falls without a register write. A captured value never changes without its channel flag being set. No interrupt line is high without its flag. Some behaviour depends on how the timer was set up over many cycles, and only the bench's cycle-level reference model can show it. This covers prescaler spacing, buffered terminal and compare values landing exactly at the period boundary, turnaround in up/down mode, the 0% and 100% PWM extremes, the three compare pin actions, and edge selection through the synchronizer.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
   localparam int DATA_W   = 16;
   localparam int ADDR_W   = 5;
   localparam int MAX_CH   = 8;
   localparam int PRE_W    = 7;   // prescaler span for exponents 0..7
   localparam int TC_BIT   = 15;
   localparam int A_CTRL   = 0;
   localparam int A_MOD    = 1;
   localparam int A_STAT   = 2;
   localparam int A_CHBASE = 8;

   typedef enum logic [1:0] {
      CH_OFF     = 2'b00,
      CH_CAPTURE = 2'b01,
      CH_COMPARE = 2'b10,
      CH_PWM     = 2'b11
   } ch_mode_e;

   typedef struct packed {
      logic       ie;
      logic [1:0] sel;
      ch_mode_e   mode;
   } ch_cfg_t;

   typedef struct packed {
      logic       tc_ie;
      logic [2:0] presc;
      logic       updown;
      logic       mod_en;
      logic       run;
   } tmr_ctrl_t;
endpackage

// File: rtl/tpwm_counter.sv
module tpwm_counter
   import tpwm_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  tmr_ctrl_t     ctrl,
   input  logic          mod_wr,
   input  logic [CW-1:0] mod_wdata,
   output logic [CW-1:0] count,
   output logic          tick,
   output logic          wrap,
   output logic          reload
);
   logic [PRE_W-1:0] pre_q, mask;
   logic [CW-1:0]    cnt_q, cnt_nx, mod_buf, mod_act, top;
   logic             down_q, down_nx;

   assign mask   = ~({PRE_W{1'b1}} << ctrl.presc);
   assign tick   = ctrl.run && ((pre_q & mask) == mask);
   assign top    = ctrl.mod_en ? mod_act : {CW{1'b1}};
   assign reload = wrap || !ctrl.run;
   assign count  = cnt_q;

   always_comb begin
      cnt_nx  = cnt_q;
      down_nx = down_q;
      wrap    = 1'b0;
      if (tick) begin
         if (!ctrl.updown) begin
            down_nx = 1'b0;
            if (cnt_q >= top) begin
               cnt_nx = '0;
               wrap   = 1'b1;
            end else begin
               cnt_nx = cnt_q + 1'b1;
            end
         end else if (!down_q) begin
            if (cnt_q >= top) begin
               if (cnt_q == '0) begin
                  wrap = 1'b1;
               end else begin
                  cnt_nx = cnt_q - 1'b1;
                  if (cnt_q == CW'(1)) wrap = 1'b1;
                  else                 down_nx = 1'b1;
               end
            end else begin
               cnt_nx = cnt_q + 1'b1;
            end
         end else begin
            cnt_nx = cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               wrap    = 1'b1;
               down_nx = 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q   <= '0;
         cnt_q   <= '0;
         down_q  <= 1'b0;
         mod_buf <= '1;
         mod_act <= '1;
      end else begin
         pre_q  <= ctrl.run ? pre_q + 1'b1 : '0;
         cnt_q  <= cnt_nx;
         down_q <= down_nx;
         if (mod_wr) mod_buf <= mod_wdata;
         if (reload) mod_act <= mod_buf;
      end
   end
endmodule

// File: rtl/tpwm_channel.sv
module tpwm_channel
   import tpwm_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [4:0]    cfg_wdata,
   input  logic          cmp_wr,
   input  logic [CW-1:0] cmp_wdata,
   input  logic [CW-1:0] count,
   input  logic          tick,
   input  logic          reload,
   input  logic          pin_in,
   output logic          pin_out,
   output logic          event_o,
   output logic          irq_en,
   output logic [CW-1:0] value
);
   ch_cfg_t       cfg_q;
   logic [CW-1:0] cmp_buf, cmp_act, cap_q;
   logic [2:0]    sync_q;
   logic          pin_q, rise, fall, match, cap_hit, cmp_hit;

   assign rise    = sync_q[1] & ~sync_q[2];
   assign fall    = ~sync_q[1] & sync_q[2];
   assign match   = tick && (count == cmp_act);
   assign cap_hit = (cfg_q.mode == CH_CAPTURE) &&
                    ((cfg_q.sel[0] && rise) || (cfg_q.sel[1] && fall));
   assign cmp_hit = (cfg_q.mode == CH_COMPARE) && match;
   assign event_o = cap_hit || cmp_hit || ((cfg_q.mode == CH_PWM) && match);
   assign irq_en  = cfg_q.ie;
   assign value   = cap_q;

   always_comb begin
      unique case (cfg_q.mode)
         CH_PWM:     pin_out = (count < cmp_act);
         CH_COMPARE: pin_out = pin_q;
         default:    pin_out = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         cmp_buf <= '0;
         cmp_act <= '0;
         cap_q   <= '0;
         sync_q  <= '0;
         pin_q   <= 1'b0;
      end else begin
         sync_q <= {sync_q[1:0], pin_in};
         if (cfg_wr) cfg_q <= ch_cfg_t'(cfg_wdata);
         if (cmp_wr) cmp_buf <= cmp_wdata;
         if (reload) cmp_act <= cmp_buf;
         if (cap_hit) cap_q <= count;
         if (cmp_hit) begin
            case (cfg_q.sel)
               2'b01:   pin_q <= ~pin_q;
               2'b10:   pin_q <= 1'b0;
               2'b11:   pin_q <= 1'b1;
               default: pin_q <= pin_q;
            endcase
         end
      end
   end
endmodule

// File: rtl/tpwm_top.sv
module tpwm_top
   import tpwm_pkg::*;
#(
   parameter int CW  = 16,
   parameter int NCH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [4:0]        wr_addr,
   input  logic [15:0]       wr_data,
   input  logic [NCH-1:0]    cap_in,
   output logic [NCH-1:0]    ch_out,
   output logic [CW-1:0]     count,
   output logic [NCH*CW-1:0] ch_value,
   output logic [NCH-1:0]    ch_flag,
   output logic              tc_flag,
   output logic [NCH-1:0]    ch_irq,
   output logic              tc_irq
);
   if (NCH < 1 || NCH > MAX_CH) begin : g_bad_nch
      $error("tpwm_top: NCH must lie in 1..%0d", MAX_CH);
   end
   if (CW < 8 || CW > DATA_W) begin : g_bad_cw
      $error("tpwm_top: CW must lie in 8..%0d", DATA_W);
   end

   tmr_ctrl_t      ctrl_q;
   logic           tick, wrap, reload, stat_wr;
   logic [NCH-1:0] evt, ie, flag_q;
   logic           tc_q;

   assign stat_wr = wr_en && (wr_addr == ADDR_W'(A_STAT));

   tpwm_counter #(.CW(CW)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl      (ctrl_q),
      .mod_wr    (wr_en && (wr_addr == ADDR_W'(A_MOD))),
      .mod_wdata (wr_data[CW-1:0]),
      .count     (count),
      .tick      (tick),
      .wrap      (wrap),
      .reload    (reload)
   );

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(A_CHBASE + 2*n);
      localparam logic [ADDR_W-1:0] CMP_A = ADDR_W'(A_CHBASE + 2*n + 1);
      tpwm_channel #(.CW(CW)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_wr    (wr_en && (wr_addr == CFG_A)),
         .cfg_wdata (wr_data[4:0]),
         .cmp_wr    (wr_en && (wr_addr == CMP_A)),
         .cmp_wdata (wr_data[CW-1:0]),
         .count     (count),
         .tick      (tick),
         .reload    (reload),
         .pin_in    (cap_in[n]),
         .pin_out   (ch_out[n]),
         .event_o   (evt[n]),
         .irq_en    (ie[n]),
         .value     (ch_value[n*CW +: CW])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         flag_q <= '0;
         tc_q   <= 1'b0;
      end else begin
         if (wr_en && (wr_addr == ADDR_W'(A_CTRL))) ctrl_q <= tmr_ctrl_t'(wr_data[6:0]);
         flag_q <= (flag_q & ~(stat_wr ? wr_data[NCH-1:0] : '0)) | evt;
         tc_q   <= (tc_q & ~(stat_wr && wr_data[TC_BIT])) | wrap;
      end
   end

   assign ch_flag = flag_q;
   assign tc_flag = tc_q;
   assign ch_irq  = flag_q & ie;
   assign tc_irq  = tc_q & ctrl_q.tc_ie;
endmodule

// File: rtl/tpwm_chk.sv
module tpwm_chk #(
   parameter int CW  = 16,
   parameter int NCH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [CW-1:0]     count,
   input logic [NCH*CW-1:0] ch_value,
   input logic [NCH-1:0]    ch_flag,
   input logic              tc_flag,
   input logic [NCH-1:0]    ch_irq,
   input logic              tc_irq
);
   // R2: the count moves by at most one step per clock, or lands on zero
   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count)) |->
      (count == '0 || count == $past(count) + 1'b1 || count == $past(count) - 1'b1));

   // R3: the terminal flag only rises together with a zero count
   assert_tc_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_flag) |-> (count == '0));

   // R9: without a register write no channel flag drops
   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> ((ch_flag & $past(ch_flag)) == $past(ch_flag)));

   // R9: the terminal flag drops only after a write
   assert_tc_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tc_flag) |-> $past(wr_en));

   // R10: no interrupt line without its flag
   assert_tc_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tc_irq |-> tc_flag);
   assert_ch_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_irq & ~ch_flag) == '0);

   // R6: a captured value only changes when its channel raises its flag
   for (genvar n = 0; n < NCH; n++) begin : g_cap
      assert_cap_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_value[n*CW +: CW] != $past(ch_value[n*CW +: CW])) |-> ch_flag[n]);
   end
endmodule

bind tpwm_top tpwm_chk #(.CW(CW), .NCH(NCH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .count    (count),
   .ch_value (ch_value),
   .ch_flag  (ch_flag),
   .tc_flag  (tc_flag),
   .ch_irq   (ch_irq),
   .tc_irq   (tc_irq)
);

// File: tb/sim_tpwm_top.sv
`timescale 1ns/1ps
module sim_tpwm_top;
   localparam int NC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [NC-1:0]    cap_in = '0;
   logic [NC-1:0]    ch_out, ch_flag, ch_irq;
   logic [15:0]      count;
   logic [NC*16-1:0] ch_value;
   logic             tc_flag, tc_irq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit chk_on = 1'b0;
   bit done = 1'b0;
   string phase = "R3";

   always #2.5 clk = ~clk;

   tpwm_top u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cap_in(cap_in), .ch_out(ch_out), .count(count), .ch_value(ch_value),
      .ch_flag(ch_flag), .tc_flag(tc_flag), .ch_irq(ch_irq), .tc_irq(tc_irq)
   );

   // ---------------- behavioural reference model ----------------
   int m_run, m_moden, m_ud, m_presc, m_tcie;
   int m_modbuf, m_modact, m_cnt, m_down, m_pre, m_tc;
   int m_mode[NC], m_sel[NC], m_ie[NC], m_cbuf[NC], m_cact[NC];
   int m_val[NC], m_flag[NC], m_pin[NC];
   int m_hist[NC][$];

   always @(posedge clk) begin : mdl
      int top, ncnt, ndown, tick, wrap, reload, per, match, rise, fall, evt, clr;
      if (!rst_n) begin
         m_run = 0; m_moden = 0; m_ud = 0; m_presc = 0; m_tcie = 0;
         m_modbuf = 65535; m_modact = 65535; m_cnt = 0; m_down = 0; m_pre = 0; m_tc = 0;
         for (int i = 0; i < NC; i++) begin
            m_mode[i] = 0; m_sel[i] = 0; m_ie[i] = 0; m_cbuf[i] = 0; m_cact[i] = 0;
            m_val[i] = 0; m_flag[i] = 0; m_pin[i] = 0;
            m_hist[i] = '{0, 0, 0};
         end
      end else begin
         per  = 1 << m_presc;
         tick = m_run && ((m_pre % per) == per - 1);
         top  = m_moden ? m_modact : 65535;
         ncnt = m_cnt; ndown = m_down; wrap = 0;
         if (tick) begin
            if (m_ud == 0) begin
               ndown = 0;
               if (m_cnt >= top) begin ncnt = 0; wrap = 1; end
               else ncnt = m_cnt + 1;
            end else if (m_down == 0) begin
               if (m_cnt < top) ncnt = m_cnt + 1;
               else if (m_cnt == 0) wrap = 1;
               else begin
                  ncnt = m_cnt - 1;
                  if (ncnt == 0) wrap = 1; else ndown = 1;
               end
            end else begin
               ncnt = m_cnt - 1;
               if (ncnt == 0) begin wrap = 1; ndown = 0; end
            end
         end
         reload = wrap || !m_run;
         for (int i = 0; i < NC; i++) begin
            match = tick && (m_cnt == m_cact[i]);
            rise = m_hist[i][1] && !m_hist[i][2];
            fall = !m_hist[i][1] && m_hist[i][2];
            evt = 0;
            if (m_mode[i] == 1 && (((m_sel[i] & 1) && rise) || ((m_sel[i] & 2) && fall))) begin
               m_val[i] = m_cnt; evt = 1;
            end
            if (m_mode[i] == 2 && match) begin
               evt = 1;
               if (m_sel[i] == 1) m_pin[i] = !m_pin[i];
               else if (m_sel[i] == 2) m_pin[i] = 0;
               else if (m_sel[i] == 3) m_pin[i] = 1;
            end
            if (m_mode[i] == 3 && match) evt = 1;
            clr = wr_en && wr_addr == 2 && wr_data[i];
            m_flag[i] = (m_flag[i] && !clr) || evt;
            if (reload) m_cact[i] = m_cbuf[i];
            if (wr_en && wr_addr == 5'(8 + 2*i)) begin
               m_mode[i] = wr_data[1:0]; m_sel[i] = wr_data[3:2]; m_ie[i] = wr_data[4];
            end
            if (wr_en && wr_addr == 5'(9 + 2*i)) m_cbuf[i] = wr_data;
            m_hist[i].push_front(cap_in[i]);
            void'(m_hist[i].pop_back());
         end
         m_tc = (m_tc && !(wr_en && wr_addr == 2 && wr_data[15])) || wrap;
         if (reload) m_modact = m_modbuf;
         if (wr_en && wr_addr == 1) m_modbuf = wr_data;
         m_pre = m_run ? (m_pre + 1) % 128 : 0;
         m_cnt = ncnt; m_down = ndown;
         if (wr_en && wr_addr == 0) begin
            m_run = wr_data[0]; m_moden = wr_data[1]; m_ud = wr_data[2];
            m_presc = wr_data[5:3]; m_tcie = wr_data[6];
         end
      end
   end

   task automatic check(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      cycles++;
      if (chk_on && rst_n) begin
         check(phase, "count", count, m_cnt);
         check("R3", "tc_flag", tc_flag, m_tc);
         check("R10", "tc_irq", tc_irq, m_tc && m_tcie);
         for (int i = 0; i < NC; i++) begin
            check(m_mode[i] == 3 ? "R8" : "R7", $sformatf("pin%0d", i), ch_out[i],
                  m_mode[i] == 3 ? (m_cnt < m_cact[i]) : (m_mode[i] == 2 ? m_pin[i] : 0));
            check("R6", $sformatf("value%0d", i), ch_value[i*16 +: 16], m_val[i]);
            check("R9", $sformatf("flag%0d", i), ch_flag[i], m_flag[i]);
            check("R10", $sformatf("irq%0d", i), ch_irq[i], m_flag[i] && m_ie[i]);
         end
      end
   end

   task automatic wr(int a, int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'(a); wr_data = 16'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pin_set(int ch, bit v, int hold);
      @(negedge clk);
      cap_in[ch] = v;
      idle(hold);
   endtask

   initial begin : watchdog
      while (!done && cycles < 200000) @(negedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      int held;
      idle(3);
      // R1: reset state
      check("R1", "count", count, 0);
      check("R1", "ch_flag", ch_flag, 0);
      check("R1", "tc_flag", tc_flag, 0);
      check("R1", "ch_out", ch_out, 0);
      check("R1", "irqs", {ch_irq, tc_irq}, 0);
      check("R1", "ch_value", ch_value, 0);
      rst_n = 1'b1;
      chk_on = 1'b1;

      // R3: modulo up counting with PWM, compare and capture channels
      phase = "R3";
      wr(1, 9);
      wr(8, 'h13);  wr(9, 4);     // ch0 PWM, ie
      wr(10, 'h16); wr(11, 7);    // ch1 compare toggle, ie
      wr(12, 'h15);               // ch2 capture rising, ie
      wr(14, 'h0E); wr(15, 2);    // ch3 compare set
      wr(0, 'h43);
      idle(30);
      check("R7", "ch3 set on match", ch_out[3], 1);
      pin_set(2, 1, 7); pin_set(2, 0, 5); pin_set(2, 1, 9);
      wr(2, 'h800F);
      idle(12);

      // R2: prescaler and stop
      phase = "R2";
      wr(0, 'h53);
      idle(80);
      wr(0, 'h42);
      idle(2);
      held = count;
      idle(10);
      check("R2", "count holds while stopped", count, held);

      // R5: buffered modulo and compare
      phase = "R5";
      wr(1, 3);
      wr(0, 'h43);
      idle(20);
      wr(1, 12); wr(9, 10);
      idle(60);

      // R4: up/down counting
      phase = "R4";
      wr(1, 5);
      wr(0, 'h47);
      idle(50);

      // R8: PWM extremes
      phase = "R4";
      wr(9, 0);
      idle(30);
      for (int k = 0; k < 20; k++) begin
         check("R8", "0% duty", ch_out[0], 0);
         idle(1);
      end
      wr(9, 20);
      idle(30);
      for (int k = 0; k < 20; k++) begin
         check("R8", "100% duty", ch_out[0], 1);
         idle(1);
      end

      // R6: falling and both-edge capture
      wr(12, 'h19);
      pin_set(2, 0, 6); pin_set(2, 1, 6);
      wr(12, 'h1D);
      pin_set(2, 0, 6); pin_set(2, 1, 6);

      // R7: clear and set actions
      wr(11, 3);
      wr(10, 'h1A);
      idle(25);
      wr(10, 'h1E);
      idle(25);

      // R9: zero bits keep flags; one bits clear them
      wr(14, 0);
      idle(4);
      held = ch_flag[3];
      wr(2, 0);
      check("R9", "zero write keeps flag", ch_flag[3], held);
      wr(2, 'h0008);
      idle(3);
      check("R9", "w1c clears flag", ch_flag[3], 0);

      // R3: free running wrap at all ones
      phase = "R3";
      wr(0, 'h41);
      wr(2, 'h800F);
      idle(65600);
      check("R3", "free-run terminal flag", tc_flag, 1);
      check("R10", "terminal irq", tc_irq, 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule